// File: doc/BRIEF.md
# Descriptor-Driven Transfer Controller

This block moves one data word from a source address to a destination address each time an activation arrives. It is started by a pulse on one of several hardware request lines or by a software request. The parameters of each move are held in memory as a descriptor. A vector table, indexed by the activating source or by the software vector number, gives the descriptor's start address. The controller loads the descriptor and performs one read followed by one write. It then steps the addresses and the count, writes them back, and follows chain links to further descriptors within the same activation.

When the last descriptor of a chain completes, a per-source rule decides the outcome. For a hardware source, the rule decides whether the source's enable bit is cleared and a one-cycle CPU interrupt pulse is raised. For a software request, it decides whether the trigger bit is cleared or kept set together with a software interrupt pulse. A small register block holds the per-source enables and the software vector register. Memory is a single-port bus whose read data returns one cycle after the request.

Memory map used by the block: vector entry for vector `v` at `VEC_BASE + v`. A descriptor at base `b` holds: `b+0` mode word A, `b+1` mode word B, `b+2` source address, `b+3` destination address, `b+4` transfer count, `b+5` a second count word that the block leaves untouched.

Top module: `desc_xfer_ctrl`

## Requirements
- R1: On activation with vector `v`, the block reads the descriptor base from memory word `VEC_BASE+v`, then loads words base+0..base+4 as mode A, mode B, source, destination and count. Hardware source `s` uses vector `s`.
- R2: Each descriptor causes exactly one read at the source address, followed by a write of the data read to the destination address.
- R3: Mode A bits [1:0] control the source address and bits [3:2] control the destination address: 1 increments, 2 decrements, 0 or 3 leaves it fixed. The step is 2 when mode A bit 4 is 1, otherwise 1. The count decrements by one. The new source, destination and count are written back to base+2, base+3 and base+4.
- R4: When mode B bit 0 (chain) is 1, the descriptor at base+6 is executed next in the same activation. A chain of n links therefore performs n+1 transfers.
- R5: A pulse on `irq_in[s]` is latched as pending only while enable bit `s` (register 0, bit `s`) is 1. Pending hardware sources are served lowest number first, and all of them are served before a software request.
- R6: For a hardware activation, if the last descriptor's count reaches 0 or its mode B bit 1 (interrupt select) is 1, enable bit `s` is cleared and `cpu_irq[s]` pulses for one cycle. Otherwise the enable bit stays set and no pulse is raised.
- R7: A write to register 1 sets the trigger (bit 7) and the vector (bits VW-1:0), and a request is issued when bit 7 is written as 1. Such a write is ignored entirely while the trigger is already 1.
- R8: For a software activation, if the last descriptor's count reaches 0 or its interrupt select is 1, the trigger stays 1 and `sw_irq` pulses for one cycle. Otherwise the trigger is cleared and no pulse is raised.
- R9: `busy` is high from dispatch until the block returns to idle. Requests that arrive while busy stay pending and are served afterwards.
- R10: After reset, `busy`, `cpu_irq`, `sw_irq`, both registers and all pending requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NSRC | Hardware activation pulses, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 enables, 1 software vector |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid the cycle after a read request |
| busy | output | 1 | Block is servicing an activation |
| cpu_irq | output | NSRC | One-cycle CPU interrupt pulse per hardware source |
| sw_irq | output | 1 | One-cycle CPU interrupt pulse for software activations |

## Verification
The assertions check the following on every cycle:
- a pending request is held until its own dispatch, and it is never created from a disabled source;
- an ignored software write leaves the vector unchanged;
- a hardware completion with interrupt clears that source's enable bit;
- at most one CPU interrupt line pulses, and the block is idle on the following cycle;
- no memory access happens while idle.

Only the bench scenarios can show the following, because they are compared against an arithmetic model of the memory image:
- that the data moved and the written-back descriptor fields are correct for every address mode and step size;
- that chains run to their end;
- the service order among simultaneous sources;
- the trigger-bit outcome of software activations.

// File: rtl/dxc_pkg.sv
package dxc_pkg;

    localparam int DATA_W     = 16;
    localparam int NFIELDS    = 5;   // fields loaded per descriptor
    localparam int DESC_WORDS = 6;   // stride between chained descriptors
    localparam int F_MODEA    = 0;
    localparam int F_MODEB    = 1;
    localparam int F_SRC      = 2;
    localparam int F_DST      = 3;
    localparam int F_CNT      = 4;
    localparam int TRIG_BIT   = 7;

    typedef enum logic [2:0] {
        S_IDLE, S_VEC, S_BASE, S_LD, S_RD, S_WR, S_WB, S_DONE
    } eng_state_t;

    typedef enum logic [1:0] {
        AM_HOLD = 2'd0, AM_UP = 2'd1, AM_DOWN = 2'd2, AM_HOLD2 = 2'd3
    } addr_mode_t;

    function automatic logic [DATA_W-1:0] step_addr(
        input logic [DATA_W-1:0] a, input addr_mode_t m, input logic wide);
        logic [DATA_W-1:0] st;
        st = wide ? DATA_W'(2) : DATA_W'(1);
        case (m)
            AM_UP:   return a + st;
            AM_DOWN: return a - st;
            default: return a;
        endcase
    endfunction

    function automatic int lowest_set(input logic [31:0] v);
        int r;
        r = 0;
        for (int i = 31; i >= 0; i--)
            if (v[i]) r = i;
        return r;
    endfunction

endpackage

// File: rtl/dxc_regs.sv
module dxc_regs
    import dxc_pkg::*;
#(
    parameter int NSRC = 4,
    parameter int VW   = 4,
    localparam int SW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] irq_in,
    input  logic            reg_we,
    input  logic            reg_addr,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata,
    output logic            grant_valid,
    output logic            grant_sw,
    output logic [SW-1:0]   grant_src,
    output logic [VW-1:0]   grant_vec,
    input  logic            dispatch,
    input  logic            fin,
    input  logic            fin_done,
    input  logic            fin_sw,
    input  logic [SW-1:0]   fin_src
);
    logic [NSRC-1:0] en_q, pend_q, take_mask;
    logic            trig_q, swp_q, sw_wr_ok;
    logic [VW-1:0]   vec_q;

    assign sw_wr_ok  = reg_we && reg_addr && !(trig_q && reg_wdata[TRIG_BIT]);
    assign take_mask = (dispatch && !grant_sw) ? (NSRC'(1) << grant_src) : '0;

    always_comb begin
        grant_valid = (|pend_q) || swp_q;
        grant_sw    = !(|pend_q);
        grant_src   = SW'(lowest_set(32'(pend_q)));
        grant_vec   = grant_sw ? vec_q : VW'(grant_src);
        reg_rdata   = '0;
        if (reg_addr) begin
            reg_rdata[TRIG_BIT] = trig_q;
            reg_rdata[VW-1:0]   = vec_q;
        end else begin
            reg_rdata[NSRC-1:0] = en_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pend_q <= '0;
            trig_q <= 1'b0;
            swp_q  <= 1'b0;
            vec_q  <= '0;
        end else begin
            pend_q <= (pend_q & ~take_mask) | (irq_in & en_q);
            if (reg_we && !reg_addr) en_q <= reg_wdata[NSRC-1:0];
            if (fin && !fin_sw && fin_done) en_q[fin_src] <= 1'b0;
            if (dispatch && grant_sw) swp_q <= 1'b0;
            if (sw_wr_ok) begin
                trig_q <= reg_wdata[TRIG_BIT];
                swp_q  <= reg_wdata[TRIG_BIT];
                vec_q  <= reg_wdata[VW-1:0];
            end
            if (fin && fin_sw && !fin_done) trig_q <= 1'b0;
        end
    end

    p_ignore_rearm_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr && trig_q && reg_wdata[TRIG_BIT]) |=> $stable(vec_q));

    for (genvar s = 0; s < NSRC; s++) begin : g_chk
        p_en_clear_r6: assert property (@(posedge clk) disable iff (rst)
            (fin && !fin_sw && fin_done && fin_src == SW'(s)) |=> !en_q[s]);
        p_pend_hold_r9: assert property (@(posedge clk) disable iff (rst)
            (pend_q[s] && !take_mask[s]) |=> pend_q[s]);
        p_gate_r5: assert property (@(posedge clk) disable iff (rst)
            (!pend_q[s] && !(irq_in[s] && en_q[s])) |=> !pend_q[s]);
    end

endmodule

// File: rtl/dxc_engine.sv
module dxc_engine
    import dxc_pkg::*;
#(
    parameter int NSRC     = 4,
    parameter int VW       = 4,
    parameter int AW       = 8,
    parameter int VEC_BASE = 0,
    localparam int SW      = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int IW      = $clog2(NFIELDS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              grant_valid,
    input  logic              grant_sw,
    input  logic [SW-1:0]     grant_src,
    input  logic [VW-1:0]     grant_vec,
    output logic              dispatch,
    output logic              fin,
    output logic              fin_done,
    output logic              fin_sw,
    output logic [SW-1:0]     fin_src,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy
);
    eng_state_t        state_q;
    logic [AW-1:0]     base_q;
    logic [IW-1:0]     idx_q;
    logic [DATA_W-1:0] desc_q [NFIELDS];
    logic              done_q, sw_q;
    logic [SW-1:0]     src_q;
    logic [VW-1:0]     vec_q;
    logic [DATA_W-1:0] nsrc, ndst, ncnt;

    assign dispatch = (state_q == S_IDLE) && grant_valid;
    assign fin      = (state_q == S_DONE);
    assign fin_done = done_q;
    assign fin_sw   = sw_q;
    assign fin_src  = src_q;
    assign busy     = (state_q != S_IDLE);

    always_comb begin
        nsrc = step_addr(desc_q[F_SRC], addr_mode_t'(desc_q[F_MODEA][1:0]), desc_q[F_MODEA][4]);
        ndst = step_addr(desc_q[F_DST], addr_mode_t'(desc_q[F_MODEA][3:2]), desc_q[F_MODEA][4]);
        ncnt = desc_q[F_CNT] - DATA_W'(1);
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state_q)
            S_VEC: begin
                mem_req  = 1'b1;
                mem_addr = AW'(VEC_BASE) + AW'(vec_q);
            end
            S_LD: begin
                mem_req  = (idx_q < IW'(NFIELDS));
                mem_addr = base_q + AW'(idx_q);
            end
            S_RD: begin
                mem_req  = 1'b1;
                mem_addr = desc_q[F_SRC][AW-1:0];
            end
            S_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_q[F_DST][AW-1:0];
                mem_wdata = mem_rdata;
            end
            S_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = base_q + AW'(F_SRC) + AW'(idx_q);
                mem_wdata = desc_q[IW'(F_SRC) + idx_q];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            base_q  <= '0;
            idx_q   <= '0;
            done_q  <= 1'b0;
            sw_q    <= 1'b0;
            src_q   <= '0;
            vec_q   <= '0;
            for (int i = 0; i < NFIELDS; i++) desc_q[i] <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (dispatch) begin
                    sw_q    <= grant_sw;
                    src_q   <= grant_src;
                    vec_q   <= grant_vec;
                    state_q <= S_VEC;
                end
                S_VEC:  state_q <= S_BASE;
                S_BASE: begin
                    base_q  <= mem_rdata[AW-1:0];
                    idx_q   <= '0;
                    state_q <= S_LD;
                end
                S_LD: begin
                    if (idx_q != '0) desc_q[idx_q - IW'(1)] <= mem_rdata;
                    if (idx_q == IW'(NFIELDS)) state_q <= S_RD;
                    else idx_q <= idx_q + IW'(1);
                end
                S_RD: state_q <= S_WR;
                S_WR: begin
                    desc_q[F_SRC] <= nsrc;
                    desc_q[F_DST] <= ndst;
                    desc_q[F_CNT] <= ncnt;
                    done_q  <= (ncnt == '0) || desc_q[F_MODEB][1];
                    idx_q   <= '0;
                    state_q <= S_WB;
                end
                S_WB: begin
                    if (idx_q == IW'(F_CNT - F_SRC)) begin
                        idx_q <= '0;
                        if (desc_q[F_MODEB][0]) begin
                            base_q  <= base_q + AW'(DESC_WORDS);
                            state_q <= S_LD;
                        end else begin
                            state_q <= S_DONE;
                        end
                    end else begin
                        idx_q <= idx_q + IW'(1);
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    p_busy_after_dispatch_r9: assert property (@(posedge clk) disable iff (rst)
        dispatch |=> busy);
    p_quiet_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);
    p_write_after_read_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && state_q == S_WR) |-> $past(mem_req && !mem_we));

endmodule

// File: rtl/desc_xfer_ctrl.sv
module desc_xfer_ctrl
    import dxc_pkg::*;
#(
    parameter int NSRC     = 4,
    parameter int VW       = 4,
    parameter int AW       = 8,
    parameter int VEC_BASE = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   irq_in,
    input  logic              reg_we,
    input  logic              reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic [NSRC-1:0]   cpu_irq,
    output logic              sw_irq
);
    localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic          grant_valid, grant_sw, dispatch, fin, fin_done, fin_sw;
    logic [SW-1:0] grant_src, fin_src;
    logic [VW-1:0] grant_vec;

    dxc_regs #(.NSRC(NSRC), .VW(VW)) regs_i (
        .clk(clk), .rst(rst), .irq_in(irq_in),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .grant_valid(grant_valid), .grant_sw(grant_sw), .grant_src(grant_src),
        .grant_vec(grant_vec), .dispatch(dispatch),
        .fin(fin), .fin_done(fin_done), .fin_sw(fin_sw), .fin_src(fin_src)
    );

    dxc_engine #(.NSRC(NSRC), .VW(VW), .AW(AW), .VEC_BASE(VEC_BASE)) eng_i (
        .clk(clk), .rst(rst),
        .grant_valid(grant_valid), .grant_sw(grant_sw), .grant_src(grant_src),
        .grant_vec(grant_vec), .dispatch(dispatch),
        .fin(fin), .fin_done(fin_done), .fin_sw(fin_sw), .fin_src(fin_src),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy)
    );

    assign cpu_irq = (fin && !fin_sw && fin_done) ? (NSRC'(1) << fin_src) : '0;
    assign sw_irq  = fin && fin_sw && fin_done;

    p_irq_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cpu_irq, sw_irq}));
    p_irq_then_idle_r9: assert property (@(posedge clk) disable iff (rst)
        ((|cpu_irq) || sw_irq) |=> !busy);

endmodule

// File: tb/desc_xfer_ctrl_tb_top.sv
module desc_xfer_ctrl_tb_top;
    localparam int NSRC = 4;
    localparam int VEC  = 0;

    logic        clk = 1'b0, rst = 1'b1;
    logic [3:0]  irq_in = '0;
    logic        reg_we = 1'b0, reg_addr = 1'b0;
    logic [7:0]  reg_wdata = '0, reg_rdata;
    logic        mem_req, mem_we, busy, sw_irq;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata, mem_rdata = '0;
    logic [3:0]  cpu_irq;

    logic [15:0] mem [256];
    logic [15:0] exp_mem [256];
    logic        bw_en = 1'b0;
    logic [7:0]  bw_addr = '0;
    logic [15:0] bw_data = '0;

    int nchk = 0, nfail = 0;
    int irq_cnt [4] = '{0, 0, 0, 0};
    int sw_cnt = 0, nord = 0;
    int order [64];
    logic [3:0] exp_en;

    always #5 clk = ~clk;

    desc_xfer_ctrl dut_i (
        .clk(clk), .rst(rst), .irq_in(irq_in), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .cpu_irq(cpu_irq), .sw_irq(sw_irq)
    );

    always @(posedge clk) begin
        if (bw_en) mem[bw_addr] <= bw_data;
        if (mem_req) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else mem_rdata <= mem[mem_addr];
        end
        if (!rst) begin
            for (int s = 0; s < NSRC; s++)
                if (cpu_irq[s]) begin irq_cnt[s] <= irq_cnt[s] + 1; order[nord % 64] <= s; end
            if (sw_irq) begin sw_cnt <= sw_cnt + 1; order[nord % 64] <= 8; end
            if ((|cpu_irq) || sw_irq) nord <= nord + 1;
        end
    end

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_mem(string req);
        int bad = 0, first = -1;
        for (int a = 0; a < 256; a++)
            if (mem[a] !== exp_mem[a]) begin bad++; if (first < 0) first = a; end
        if (bad != 0) $display("  first mismatch at %0d: actual %0h expected %0h", first, mem[first], exp_mem[first]);
        chk(req, bad, 0);
    endtask

    task automatic poke(int a, int d);
        exp_mem[a] = 16'(d);
        bw_addr = 8'(a); bw_data = 16'(d); bw_en = 1'b1;
        @(negedge clk);
        bw_en = 1'b0;
    endtask

    task automatic set_desc(int b, int ma, int mb, int s, int d, int c);
        poke(b, ma); poke(b + 1, mb); poke(b + 2, s); poke(b + 3, d); poke(b + 4, c);
    endtask

    task automatic reg_write(bit a, int d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = 8'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(bit a, output int v);
        reg_addr = a; #1; v = int'(reg_rdata);
    endtask

    task automatic pulse(logic [3:0] m);
        irq_in = m;
        @(negedge clk);
        irq_in = '0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 4) begin
            @(negedge clk);
            quiet = busy ? 0 : quiet + 1;
        end
    endtask

    // arithmetic model of one activation; returns completion condition
    function automatic bit model_run(int v);
        int b = int'(exp_mem[VEC + v]) & 255;
        logic [15:0] ma, mb, s, d, c, st;
        bit dn = 1'b0, ch;
        do begin
            ma = exp_mem[b]; mb = exp_mem[(b + 1) & 255];
            s = exp_mem[(b + 2) & 255]; d = exp_mem[(b + 3) & 255]; c = exp_mem[(b + 4) & 255];
            exp_mem[d[7:0]] = exp_mem[s[7:0]];
            st = ma[4] ? 16'd2 : 16'd1;
            if (ma[1:0] == 2'd1) s = s + st; else if (ma[1:0] == 2'd2) s = s - st;
            if (ma[3:2] == 2'd1) d = d + st; else if (ma[3:2] == 2'd2) d = d - st;
            c = c - 16'd1;
            exp_mem[(b + 2) & 255] = s; exp_mem[(b + 3) & 255] = d; exp_mem[(b + 4) & 255] = c;
            dn = (c == 16'd0) || mb[1];
            ch = mb[0];
            b = (b + 6) & 255;
        end while (ch);
        return dn;
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int v, k, st0, base_irq;
        bit dn;
        for (int a = 0; a < 256; a++) begin mem[a] = 16'h0; exp_mem[a] = 16'h0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 busy", int'(busy), 0);
        chk("R10 cpu_irq", int'(cpu_irq), 0);
        reg_read(1'b0, v); chk("R10 enable reg", v, 0);
        reg_read(1'b1, v); chk("R10 swvec reg", v, 0);
        for (int a = 128; a < 256; a++) poke(a, (a * 37 + 11) & 16'hFFFF);
        for (int s = 0; s < 4; s++) poke(VEC + s, 16'h40);

        // R1 R2 R3 R6: sweep all address modes and sizes over hardware sources
        k = 0;
        for (int sm = 0; sm < 3; sm++)
            for (int dm = 0; dm < 3; dm++)
                for (int sz = 0; sz < 2; sz++) begin
                    int s = k % 4;
                    int cn = (k % 2 == 1) ? 1 : 3;
                    set_desc(16'h40, (sz << 4) | (dm << 2) | sm, 0, 16'h90 + k, 16'hC0 + 2 * k, cn);
                    reg_write(1'b0, 8'hF); exp_en = 4'hF;
                    base_irq = irq_cnt[s];
                    pulse(4'(1 << s));
                    wait_idle();
                    dn = model_run(s);
                    if (dn) exp_en[s] = 1'b0;
                    chk_mem("R2 R3 data and write-back");
                    chk("R6 irq count", irq_cnt[s] - base_irq, dn ? 1 : 0);
                    reg_read(1'b0, v); chk("R6 enable after run", v, int'(exp_en));
                    k++;
                end

        // R4 R8: software chain of three descriptors, last completes
        poke(VEC + 9, 16'h50);
        set_desc(16'h50, 16'h05, 1, 16'hA0, 16'hD0, 4);
        set_desc(16'h56, 16'h15, 1, 16'hA8, 16'hD8, 7);
        set_desc(16'h5C, 16'h0A, 0, 16'hB0, 16'hE8, 1);
        base_irq = sw_cnt;
        reg_write(1'b1, 8'h89);
        wait_idle();
        dn = model_run(9);
        chk_mem("R4 chained transfers");
        chk("R8 sw_irq on completion", sw_cnt - base_irq, 1);
        reg_read(1'b1, v); chk("R8 trigger kept", v, 16'h89);

        // R7: write with trigger while trigger set is ignored
        reg_write(1'b1, 8'h83);
        repeat (3) @(negedge clk);
        chk("R7 no activation", int'(busy), 0);
        reg_read(1'b1, v); chk("R7 register unchanged", v, 16'h89);
        chk_mem("R7 memory unchanged");
        reg_write(1'b1, 8'h09);

        // R8: count not expired, select 0 -> trigger cleared
        set_desc(16'h50, 16'h05, 0, 16'hA0, 16'hD0, 5);
        base_irq = sw_cnt;
        reg_write(1'b1, 8'h89);
        wait_idle();
        dn = model_run(9);
        chk_mem("R8 data");
        chk("R8 no sw_irq", sw_cnt - base_irq, 0);
        reg_read(1'b1, v); chk("R8 trigger cleared", v, 16'h09);

        // R8: interrupt select with count left
        set_desc(16'h50, 16'h05, 2, 16'hA0, 16'hD0, 5);
        reg_write(1'b1, 8'h89);
        wait_idle();
        dn = model_run(9);
        chk("R8 select irq", sw_cnt - base_irq, 1);
        reg_read(1'b1, v); chk("R8 select keeps trigger", v, 16'h89);
        reg_write(1'b1, 8'h00);

        // R6: hardware interrupt select with count left
        set_desc(16'h40, 16'h05, 2, 16'h90, 16'hC8, 9);
        reg_write(1'b0, 8'hF);
        base_irq = irq_cnt[1];
        pulse(4'b0010);
        wait_idle();
        dn = model_run(1);
        chk_mem("R6 data");
        chk("R6 select irq", irq_cnt[1] - base_irq, 1);
        reg_read(1'b0, v); chk("R6 enable bit 1 cleared", v, 16'hD);

        // R5: disabled source pulse is not latched
        reg_write(1'b0, 8'h0);
        pulse(4'b0001);
        repeat (2) @(negedge clk);
        chk("R5 disabled no busy", int'(busy), 0);
        reg_write(1'b0, 8'h1);
        repeat (4) @(negedge clk);
        chk("R5 no stale pending", int'(busy), 0);
        chk_mem("R5 memory untouched");
        chk("R5 no irq", irq_cnt[0], 0);

        // R5 R9: simultaneous sources, order and pending while busy
        poke(VEC + 1, 16'h60); poke(VEC + 2, 16'h68); poke(VEC + 3, 16'h70);
        set_desc(16'h60, 16'h05, 0, 16'h84, 16'hF0, 1);
        set_desc(16'h68, 16'h05, 0, 16'h86, 16'hF2, 1);
        set_desc(16'h70, 16'h05, 0, 16'h88, 16'hF4, 1);
        set_desc(16'h50, 16'h05, 0, 16'h8A, 16'hF6, 1);
        reg_write(1'b0, 8'hF);
        st0 = nord;
        irq_in = 4'b0110; reg_we = 1'b1; reg_addr = 1'b1; reg_wdata = 8'h89;
        @(negedge clk);
        irq_in = '0; reg_we = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 busy during service", int'(busy), 1);
        pulse(4'b1000);
        wait_idle();
        dn = model_run(1); dn = model_run(2); dn = model_run(3); dn = model_run(9);
        chk_mem("R9 all four served");
        chk("R5 first served", order[st0 % 64], 1);
        chk("R5 second served", order[(st0 + 1) % 64], 2);
        chk("R9 pending while busy served", order[(st0 + 2) % 64], 3);
        chk("R5 software last", order[(st0 + 3) % 64], 8);
        reg_read(1'b0, v); chk("R6 enables cleared", v, 16'h1);
        finish_run();
    end

endmodule